// File: doc/BRIEF.md
# Memory Protection Access Permission Checker

This block decides, for each of several access channels, whether a memory access may proceed. Each channel presents a vector of address-range hits (one bit per protection region), the privilege level of the requester and the kind of access. All channels share one table of per-region configuration bytes (lock, mode, execute, write, read) and two global policy bits: a lockdown bit that changes the meaning of the per-region bits, and a whitelist bit that changes what happens to machine-mode accesses that hit no region. The default build has three channels: two on the instruction side, the second of which covers the upper half of a fetch that may straddle a region boundary, and one on the data side.

Each channel selects the lowest-numbered active region that hits and turns its bits, the lockdown bit and the privilege level into a read/write/execute grant. With no hit, a fixed fallback policy applies. The per-channel error flags are registered once, so the verdict for inputs presented at one rising clock edge appears after that edge. Range decoding and storage of the configuration are done by the surrounding logic.

Top module: `pmp_access_checker`

## Requirements
- R1: `err_o[c]` is 1 for a denied access and 0 for an allowed one. It takes the verdict for the inputs sampled at a rising clock edge and keeps it until the next edge. While `rst_i` is high at an edge, all error flags go to 0.
- R2: Among the regions that hit, the lowest-numbered active one alone decides the verdict. A region with a higher index has no effect on the verdict.
- R3: A region whose mode field `cfg[4:3]` is `00` (off) is never treated as a hit, whatever its match bit and permission bits are.
- R4: The configuration byte holds lock at bit 5, mode at bits 4:3, execute at bit 2, write at bit 1 and read at bit 0. The access code is `00` for read, `01` for write and `10` for execute. With lockdown clear, a user access to the deciding region is allowed exactly when that region's bit for the access type is set.
- R5: With lockdown clear, a machine access is allowed when the deciding region's lock bit is 0. When the lock bit is 1, the access is allowed only when the region's bit for the access type is set.
- R6: With lockdown set and lock 0, the X W R bits give these grants. 000 gives nothing. 001 gives user read. 010 gives machine read/write and user read. 011 gives user read/write. 100 gives user execute. 101 gives user read/execute. 110 gives read/write to both levels. 111 gives user read/write/execute.
- R7: With lockdown set and lock 1, the X W R bits give these grants. 000 gives nothing. 001 gives machine read. 010 gives execute to both levels. 011 gives machine read/write. 100 gives machine execute. 101 gives machine read/execute. 110 gives machine read/execute and user execute. 111 gives read to both levels.
- R8: Privilege code `11` is machine and every other code counts as user. A user access that hits no active region is denied.
- R9: A machine execute that hits no active region is denied when the whitelist bit or the lockdown bit is set, and allowed when both are clear.
- R10: A machine read or write that hits no active region is denied when the whitelist bit is set, and allowed otherwise. The lockdown bit has no effect on this case.
- R11: The channels are independent. Each channel's flag depends only on its own hit vector, privilege and access type, together with the shared configuration and policy bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| match_i | input | NUM_CHAN x NUM_REGIONS | Per-channel region hit bits |
| cfg_i | input | NUM_REGIONS x 6 | Per-region configuration byte {lock, mode[1:0], X, W, R} |
| priv_i | input | NUM_CHAN x 2 | Per-channel privilege, 11 = machine |
| acc_i | input | NUM_CHAN x 2 | Per-channel access type: 00 read, 01 write, 10 execute |
| mml_i | input | 1 | Lockdown policy bit |
| mmwp_i | input | 1 | Whitelist policy bit |
| err_o | output | NUM_CHAN | Registered per-channel deny flag |

## Verification
The checker tests five behaviours on every cycle and for every channel: the no-hit fallback for user, machine execute and machine read/write accesses; the user grant without lockdown, taken from an independent priority search; the rule that unlocked regions allow every machine access; and the clearing of the flags by reset. The two lockdown tables, the override of a denying region by a higher-priority one, the skipping of regions that are switched off, the one-cycle latency and the separation between channels are shown only by the bench's vector table and directed scenarios.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

  // Configuration byte layout: {lock, mode[1:0], x, w, r}
  localparam int CFG_W = 6;

  localparam logic [1:0] PRIV_MACH = 2'b11;
  localparam logic [1:0] MODE_OFF  = 2'b00;

  typedef enum logic [1:0] {
    ACC_RD   = 2'b00,
    ACC_WR   = 2'b01,
    ACC_EX   = 2'b10,
    ACC_NONE = 2'b11
  } acc_e;

  typedef struct packed {
    logic       lock;
    logic [1:0] mode;
    logic       x;
    logic       w;
    logic       r;
  } rcfg_t;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;

endpackage

// File: rtl/pmp_perm_decode.sv
module pmp_perm_decode
  import pmp_chk_pkg::*;
(
  input  logic       lock_i,
  input  perm_t      bits_i,
  input  logic       mml_i,
  input  logic       mach_i,
  input  logic [1:0] acc_i,
  output logic       allow_o
);

  perm_t m_perm;
  perm_t u_perm;
  perm_t use_perm;

  // Grant table per privilege level
  always_comb begin
    m_perm = '0;
    u_perm = '0;
    if (!mml_i) begin
      u_perm = bits_i;
      m_perm = lock_i ? bits_i : 3'b111;
    end else begin
      case ({lock_i, bits_i})
        4'b0001: u_perm = 3'b001;
        4'b0010: begin m_perm = 3'b011; u_perm = 3'b001; end
        4'b0011: u_perm = 3'b011;
        4'b0100: u_perm = 3'b100;
        4'b0101: u_perm = 3'b101;
        4'b0110: begin m_perm = 3'b011; u_perm = 3'b011; end
        4'b0111: u_perm = 3'b111;
        4'b1001: m_perm = 3'b001;
        4'b1010: begin m_perm = 3'b100; u_perm = 3'b100; end
        4'b1011: m_perm = 3'b011;
        4'b1100: m_perm = 3'b100;
        4'b1101: m_perm = 3'b101;
        4'b1110: begin m_perm = 3'b101; u_perm = 3'b100; end
        4'b1111: begin m_perm = 3'b001; u_perm = 3'b001; end
        default: begin m_perm = '0; u_perm = '0; end
      endcase
    end
  end

  assign use_perm = mach_i ? m_perm : u_perm;

  always_comb begin
    case (acc_i)
      ACC_RD:  allow_o = use_perm.r;
      ACC_WR:  allow_o = use_perm.w;
      ACC_EX:  allow_o = use_perm.x;
      default: allow_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/pmp_chan_check.sv
module pmp_chan_check
  import pmp_chk_pkg::*;
#(
  parameter int NUM_REGIONS = 16
) (
  input  logic [NUM_REGIONS-1:0]            match_i,
  input  logic [NUM_REGIONS-1:0][CFG_W-1:0] cfg_i,
  input  logic [1:0]                        priv_i,
  input  logic [1:0]                        acc_i,
  input  logic                              mml_i,
  input  logic                              mmwp_i,
  output logic                              err_o
);

  logic                   mach;
  logic [NUM_REGIONS-1:0] eff_hit;
  logic [NUM_REGIONS-1:0] allow_vec;
  logic                   any_hit;
  logic                   sel_allow;

  assign mach = (priv_i == PRIV_MACH);

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
    rcfg_t rc;
    assign rc         = rcfg_t'(cfg_i[i]);
    assign eff_hit[i] = match_i[i] && (rc.mode != MODE_OFF);

    pmp_perm_decode u_dec (
      .lock_i  (rc.lock),
      .bits_i  ({rc.x, rc.w, rc.r}),
      .mml_i   (mml_i),
      .mach_i  (mach),
      .acc_i   (acc_i),
      .allow_o (allow_vec[i])
    );
  end

  // Lowest index wins: scan from the top so lower indices overwrite
  always_comb begin
    any_hit   = 1'b0;
    sel_allow = 1'b0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (eff_hit[i]) begin
        any_hit   = 1'b1;
        sel_allow = allow_vec[i];
      end
    end
  end

  // Fallback policy when no active region hits
  always_comb begin
    if (any_hit)             err_o = !sel_allow;
    else if (!mach)          err_o = 1'b1;
    else if (acc_i == ACC_EX) err_o = mmwp_i || mml_i;
    else                     err_o = mmwp_i;
  end

endmodule

// File: rtl/pmp_access_checker.sv
module pmp_access_checker
  import pmp_chk_pkg::*;
#(
  parameter int NUM_CHAN    = 3,
  parameter int NUM_REGIONS = 16
) (
  input  logic                                clk_i,
  input  logic                                rst_i,
  input  logic [NUM_CHAN-1:0][NUM_REGIONS-1:0] match_i,
  input  logic [NUM_REGIONS-1:0][CFG_W-1:0]   cfg_i,
  input  logic [NUM_CHAN-1:0][1:0]            priv_i,
  input  logic [NUM_CHAN-1:0][1:0]            acc_i,
  input  logic                                mml_i,
  input  logic                                mmwp_i,
  output logic [NUM_CHAN-1:0]                 err_o
);

  logic [NUM_CHAN-1:0] err_d;

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    pmp_chan_check #(
      .NUM_REGIONS (NUM_REGIONS)
    ) u_chan (
      .match_i (match_i[c]),
      .cfg_i   (cfg_i),
      .priv_i  (priv_i[c]),
      .acc_i   (acc_i[c]),
      .mml_i   (mml_i),
      .mmwp_i  (mmwp_i),
      .err_o   (err_d[c])
    );
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) err_o <= '0;
    else       err_o <= err_d;
  end

endmodule

// File: rtl/pmp_access_checker_chk.sv
module pmp_access_checker_chk
  import pmp_chk_pkg::*;
#(
  parameter int NUM_CHAN    = 3,
  parameter int NUM_REGIONS = 16
) (
  input logic                                 clk_i,
  input logic                                 rst_i,
  input logic [NUM_CHAN-1:0][NUM_REGIONS-1:0] match_i,
  input logic [NUM_REGIONS-1:0][CFG_W-1:0]    cfg_i,
  input logic [NUM_CHAN-1:0][1:0]             priv_i,
  input logic [NUM_CHAN-1:0][1:0]             acc_i,
  input logic                                 mml_i,
  input logic                                 mmwp_i,
  input logic [NUM_CHAN-1:0]                  err_o
);

  logic [NUM_CHAN-1:0]            hit;
  logic [NUM_CHAN-1:0]            lock_seen;
  logic [NUM_CHAN-1:0][CFG_W-1:0] pick;
  logic [NUM_CHAN-1:0]            want;

  // Independent priority search per channel
  always_comb begin
    hit       = '0;
    lock_seen = '0;
    pick      = '0;
    want      = '0;
    for (int c = 0; c < NUM_CHAN; c++) begin
      for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
        if (match_i[c][i] && (cfg_i[i][4:3] != 2'b00)) begin
          hit[c]  = 1'b1;
          pick[c] = cfg_i[i];
          if (cfg_i[i][5]) lock_seen[c] = 1'b1;
        end
      end
      case (acc_i[c])
        2'b00:   want[c] = pick[c][0];
        2'b01:   want[c] = pick[c][1];
        2'b10:   want[c] = pick[c][2];
        default: want[c] = 1'b0;
      endcase
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    rst_i |=> (err_o == '0));

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chk
    assert_user_nohit_deny_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      (priv_i[c] != 2'b11 && !hit[c]) |=> err_o[c]);

    assert_mach_exec_nohit_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      (priv_i[c] == 2'b11 && acc_i[c] == 2'b10 && !hit[c])
      |=> (err_o[c] == $past(mml_i || mmwp_i)));

    assert_mach_data_nohit_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      (priv_i[c] == 2'b11 && (acc_i[c] == 2'b00 || acc_i[c] == 2'b01) && !hit[c])
      |=> (err_o[c] == $past(mmwp_i)));

    assert_user_grant_plain_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (!mml_i && priv_i[c] != 2'b11 && hit[c]) |=> (err_o[c] == !$past(want[c])));

    assert_mach_unlocked_allow_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (!mml_i && priv_i[c] == 2'b11 && hit[c] && !lock_seen[c]) |=> !err_o[c]);
  end

endmodule

bind pmp_access_checker pmp_access_checker_chk #(
  .NUM_CHAN    (NUM_CHAN),
  .NUM_REGIONS (NUM_REGIONS)
) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .match_i (match_i),
  .cfg_i   (cfg_i),
  .priv_i  (priv_i),
  .acc_i   (acc_i),
  .mml_i   (mml_i),
  .mmwp_i  (mmwp_i),
  .err_o   (err_o)
);

// File: tb/sim_pmp_access_checker.sv
module sim_pmp_access_checker;

  localparam int NC = 3;
  localparam int NR = 4;

  logic                   clk_i = 1'b0;
  logic                   rst_i = 1'b1;
  logic [NC-1:0][NR-1:0]  match_i = '0;
  logic [NR-1:0][5:0]     cfg_i = '0;
  logic [NC-1:0][1:0]     priv_i = '0;
  logic [NC-1:0][1:0]     acc_i = '0;
  logic                   mml_i = 1'b0;
  logic                   mmwp_i = 1'b0;
  logic [NC-1:0]          err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  pmp_access_checker #(.NUM_CHAN(NC), .NUM_REGIONS(NR)) u0 (
    .clk_i (clk_i), .rst_i (rst_i), .match_i (match_i), .cfg_i (cfg_i),
    .priv_i (priv_i), .acc_i (acc_i), .mml_i (mml_i), .mmwp_i (mmwp_i),
    .err_o (err_o)
  );

  // {req[3:0], mml, mmwp, priv, acc, match[3:0], cfg r3..r0, expected}
  function automatic logic [38:0] V(input int rq, input logic ml, input logic mw,
                                    input logic [1:0] pr, input logic [1:0] ac,
                                    input logic [3:0] m, input logic [5:0] c1,
                                    input logic [5:0] c0, input logic e);
    logic [3:0] rq4;
    rq4 = rq[3:0];
    return {rq4, ml, mw, pr, ac, m, 6'b0, 6'b0, c1, c0, e};
  endfunction

  localparam logic [1:0] M = 2'b11, U = 2'b00, S = 2'b01;
  localparam logic [1:0] RD = 2'b00, WR = 2'b01, EX = 2'b10;
  localparam int NV = 39;
  localparam logic [38:0] TBL [NV] = '{
    V(4, 0, 0, U, RD, 4'b0001, 6'o00, 6'b011001, 0),   // R4
    V(4, 0, 0, U, WR, 4'b0001, 6'o00, 6'b011001, 1),   // R4
    V(4, 0, 0, U, EX, 4'b0001, 6'o00, 6'b011100, 0),   // R4
    V(4, 0, 0, U, EX, 4'b0001, 6'o00, 6'b011011, 1),   // R4
    V(5, 0, 0, M, WR, 4'b0001, 6'o00, 6'b011000, 0),   // R5
    V(5, 0, 0, M, RD, 4'b0001, 6'o00, 6'b111000, 1),   // R5
    V(5, 0, 0, M, EX, 4'b0001, 6'o00, 6'b111100, 0),   // R5
    V(5, 0, 1, M, WR, 4'b0001, 6'o00, 6'b111011, 0),   // R5
    V(6, 1, 0, M, RD, 4'b0001, 6'o00, 6'b011010, 0),   // R6
    V(6, 1, 0, U, WR, 4'b0001, 6'o00, 6'b011010, 1),   // R6
    V(6, 1, 0, U, RD, 4'b0001, 6'o00, 6'b011010, 0),   // R6
    V(6, 1, 0, U, WR, 4'b0001, 6'o00, 6'b011110, 0),   // R6
    V(6, 1, 0, M, WR, 4'b0001, 6'o00, 6'b011110, 0),   // R6
    V(6, 1, 0, M, RD, 4'b0001, 6'o00, 6'b011001, 1),   // R6
    V(6, 1, 0, U, EX, 4'b0001, 6'o00, 6'b011101, 0),   // R6
    V(6, 1, 0, M, EX, 4'b0001, 6'o00, 6'b011111, 1),   // R6
    V(7, 1, 0, M, EX, 4'b0001, 6'o00, 6'b111010, 0),   // R7
    V(7, 1, 0, U, EX, 4'b0001, 6'o00, 6'b111010, 0),   // R7
    V(7, 1, 0, U, RD, 4'b0001, 6'o00, 6'b111111, 0),   // R7
    V(7, 1, 0, M, WR, 4'b0001, 6'o00, 6'b111111, 1),   // R7
    V(7, 1, 0, M, RD, 4'b0001, 6'o00, 6'b111000, 1),   // R7
    V(7, 1, 0, U, EX, 4'b0001, 6'o00, 6'b111110, 0),   // R7
    V(7, 1, 0, M, WR, 4'b0001, 6'o00, 6'b111011, 0),   // R7
    V(7, 1, 0, U, RD, 4'b0001, 6'o00, 6'b111011, 1),   // R7
    V(7, 1, 0, M, EX, 4'b0001, 6'o00, 6'b111100, 0),   // R7
    V(7, 1, 0, U, EX, 4'b0001, 6'o00, 6'b111100, 1),   // R7
    V(2, 0, 0, U, RD, 4'b0011, 6'b011000, 6'b011001, 0), // R2 low allows
    V(2, 0, 0, U, RD, 4'b0011, 6'b011001, 6'b011000, 1), // R2 low denies
    V(3, 0, 0, U, RD, 4'b0011, 6'b011001, 6'b000001, 0), // R3 off skipped
    V(3, 1, 0, M, EX, 4'b0001, 6'o00, 6'b000100, 1),     // R3 off -> no hit
    V(8, 0, 0, U, RD, 4'b0000, 6'o00, 6'o00, 1),         // R8
    V(8, 0, 0, S, RD, 4'b0001, 6'o00, 6'b011000, 1),     // R8 code 01 is user
    V(8, 0, 0, 2'b10, EX, 4'b0000, 6'o00, 6'o00, 1),     // R8 code 10 is user
    V(9, 0, 0, M, EX, 4'b0000, 6'o00, 6'o00, 0),         // R9
    V(9, 0, 1, M, EX, 4'b0000, 6'o00, 6'o00, 1),         // R9
    V(9, 1, 0, M, EX, 4'b0000, 6'o00, 6'o00, 1),         // R9
    V(10, 1, 0, M, WR, 4'b0000, 6'o00, 6'o00, 0),        // R10
    V(10, 0, 1, M, RD, 4'b0000, 6'o00, 6'o00, 1),        // R10
    V(10, 0, 0, M, RD, 4'b0000, 6'o00, 6'o00, 0)         // R10
  };

  task automatic check(input int rq, input logic [NC-1:0] got,
                       input logic [NC-1:0] exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d %s: got %b expected %b", rq, what, got, exp);
    end
  endtask

  task automatic drive_all(input logic ml, input logic mw, input logic [1:0] pr,
                           input logic [1:0] ac, input logic [3:0] m,
                           input logic [23:0] cf);
    mml_i  = ml;
    mmwp_i = mw;
    cfg_i  = cf;
    for (int ch = 0; ch < NC; ch++) begin
      match_i[ch] = m;
      priv_i[ch]  = pr;
      acc_i[ch]   = ac;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(1, err_o, 3'b000, "flags during reset");
    rst_i = 1'b0;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk_i);
      drive_all(TBL[k][34], TBL[k][33], TBL[k][32:31], TBL[k][30:29],
                TBL[k][28:25], TBL[k][24:1]);
      @(negedge clk_i);
      check(int'(TBL[k][38:35]), err_o, {NC{TBL[k][0]}}, $sformatf("vector %0d", k));
    end

    // R1: one-cycle latency and synchronous reset
    drive_all(0, 0, U, RD, 4'b0000, 24'h0);
    @(negedge clk_i);
    check(1, err_o, 3'b111, "denied after edge");
    drive_all(0, 0, M, RD, 4'b0000, 24'h0);
    #2;
    check(1, err_o, 3'b111, "held before next edge");
    @(negedge clk_i);
    check(1, err_o, 3'b000, "updated after edge");
    drive_all(0, 0, U, RD, 4'b0000, 24'h0);
    rst_i = 1'b1;
    @(negedge clk_i);
    check(1, err_o, 3'b000, "reset clears flags");
    rst_i = 1'b0;
    @(negedge clk_i);
    check(1, err_o, 3'b111, "verdict after reset release");

    // R11: channels decided independently
    drive_all(0, 0, U, RD, 4'b0000, {18'b0, 6'b011001});
    priv_i[1] = M; acc_i[1] = EX;
    priv_i[2] = M; acc_i[2] = RD; match_i[2] = 4'b0001;
    @(negedge clk_i);
    check(11, err_o, 3'b001, "mixed channels A");
    priv_i[0] = M; acc_i[0] = EX;
    priv_i[1] = U; acc_i[1] = RD;
    @(negedge clk_i);
    check(11, err_o, 3'b010, "mixed channels B");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule